// File: doc/BRIEF.md
# Output data rate sequencer

This block sits between a sensor's analog-to-digital converter and the logic that consumes its readings. A fixed-rate slot strobe marks every point at which a conversion may start. A 4-bit rate code selects one of ten output rates, each half of the one above. For each strobe the block decides whether the converter is powered for that slot. It accepts the converter's signed result and forwards it as an output sample with a one-cycle valid pulse. At the two fastest rates results are forwarded raw. At the next four rates every slot converts and results are averaged over a boxcar window. At the slowest rates the averaging window stays at 32 slots, so the bandwidth stays that of the 100 Hz setting. Those 32 slots sit at the end of a longer reporting period, and the converter stays off for the rest of the period to save power.

A rate change restarts the slot phase and discards any partial window. The first output in the new setting therefore always reflects a complete window. A result that arrives for a slot the block did not enable is dropped.

Top module: `odr_rate_seq`

## Requirements
- R1: After reset the rate register holds code 15, `adc_en` and `out_valid` are low, and `adc_en` is high only in a cycle in which `slot_stb` is high.
- R2: With code 15 (3200 Hz) every strobe asserts `adc_en`. Each accepted sample appears unchanged on `out_data`, with `out_valid` high in the cycle after the sample's `adc_valid` cycle.
- R3: With code 14 (1600 Hz) `adc_en` is asserted on the 2nd, 4th, 6th... strobe after the code took effect and is low on the others. Each accepted sample is output unfiltered.
- R4: With codes 13, 12, 11, 10 every strobe asserts `adc_en`. One output is produced per N = 2^(15-code) accepted samples (4, 8, 16, 32): the mean of those N samples.
- R5: With codes 9 down to 6, and codes 0 to 5 treated as 6, the reporting period is P = 2^(15-code) slots (64 to 512). `adc_en` is asserted only on the last 32 slots of each period, and each period yields one output: the mean of those 32 samples.
- R6: Means are computed from a full-width sum and rounded toward zero. For example, samples -2, -1, -1, -1 give -1.
- R7: When `odr_code` differs from the held code, that cycle neither enables a slot nor accepts a sample. The slot phase and partial sum are cleared, and no output is produced until a full window in the new setting has been accepted.
- R8: An `adc_valid` pulse is ignored unless an enabled slot is waiting for its result. After one result is taken for a slot, further pulses are ignored until the next enabled slot.
- R9: `out_valid` is a single-cycle pulse per completed window and never stays high for two consecutive cycles under strobe-spaced stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_stb | input | 1 | One-cycle pulse marking each 3200 Hz conversion slot |
| odr_code | input | 4 | Output rate select; 15 is 3200 Hz, each step down halves it |
| adc_data | input | 13 | Signed converter result |
| adc_valid | input | 1 | Converter result strobe |
| adc_en | output | 1 | Converter enable / power gate for the current slot |
| out_data | output | 13 | Signed output sample (raw or averaged) |
| out_valid | output | 1 | One-cycle pulse when `out_data` is new |

## Verification
The hardest case to reach is the slowest duty-cycled setting. There only the last 32 of 512 slots convert, so an output needs over five hundred strobes. A spurious result falling in the long powered-down stretch must leave the next average untouched. The stimulus runs full periods at codes 9, 6 and an out-of-range code 3, and injects stray `adc_valid` pulses during off slots and right after an accepted result. It also changes the rate partway through a window, so that the discarded partial sum shows up as a missing or wrong output.

// File: rtl/odr_pkg.sv
package odr_pkg;

  typedef enum logic [1:0] {
    MD_RAW   = 2'd0,
    MD_GATED = 2'd1,
    MD_FILT  = 2'd2,
    MD_DUTY  = 2'd3
  } odr_mode_e;

  // halvings below full rate
  function automatic int rate_steps(input int code, input int full_code);
    return full_code - code;
  endfunction

  // log2 of slots per reporting period
  function automatic int period_log2(input int code, input int full_code, input int plog_max);
    int d;
    d = rate_steps(code, full_code);
    return (d > plog_max) ? plog_max : d;
  endfunction

  // log2 of averaging window length (0 means raw)
  function automatic int taps_log2(input int code, input int full_code, input int tlog_max);
    int d;
    d = rate_steps(code, full_code);
    if (d < 2) return 0;
    return (d > tlog_max) ? tlog_max : d;
  endfunction

  function automatic odr_mode_e mode_of(input int code, input int full_code, input int tlog_max);
    int d;
    d = rate_steps(code, full_code);
    if (d < 1) return MD_RAW;
    if (d == 1) return MD_GATED;
    if (d <= tlog_max) return MD_FILT;
    return MD_DUTY;
  endfunction

  // arithmetic shift with rounding toward zero
  function automatic logic signed [31:0] div_toward_zero(input logic signed [31:0] s, input int sh);
    logic signed [31:0] bias;
    bias = (s < 0) ? ((32'sd1 <<< sh) - 32'sd1) : 32'sd0;
    return (s + bias) >>> sh;
  endfunction

endpackage

// File: rtl/odr_slot_sched.sv
module odr_slot_sched
  import odr_pkg::*;
#(
  parameter int CODE_W   = 4,
  parameter int PLOG_MAX = 9,
  parameter int TLOG_MAX = 5,
  localparam int FULL_CODE = (1 << CODE_W) - 1,
  localparam int TL_W      = $clog2(TLOG_MAX + 1),
  localparam int ECNT_W    = TLOG_MAX + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_stb,
  input  logic [CODE_W-1:0] odr_code,
  input  logic              adc_valid,
  output logic              adc_en,
  output logic              accept,
  output logic              odr_chg,
  output logic [TL_W-1:0]   tlog,
  output odr_mode_e         mode
);

  logic [CODE_W-1:0]   odr_q;
  logic [PLOG_MAX-1:0] phase;
  logic                armed;
  logic                in_win;
  logic                last_ph;
  int                  plog_i;
  int                  tlog_i;
  int                  per_i;
  int                  win_i;

  always_comb begin
    plog_i  = period_log2(int'(odr_q), FULL_CODE, PLOG_MAX);
    tlog_i  = taps_log2(int'(odr_q), FULL_CODE, TLOG_MAX);
    per_i   = 1 << plog_i;
    win_i   = per_i - (1 << tlog_i);
    in_win  = int'(phase) >= win_i;
    last_ph = int'(phase) == (per_i - 1);
    mode    = mode_of(int'(odr_q), FULL_CODE, TLOG_MAX);
    tlog    = TL_W'(tlog_i);
  end

  assign odr_chg = (odr_code != odr_q);
  assign adc_en  = slot_stb & ~odr_chg & in_win;
  assign accept  = adc_valid & armed & ~odr_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odr_q <= CODE_W'(FULL_CODE);
      phase <= '0;
      armed <= 1'b0;
    end else if (odr_chg) begin
      odr_q <= odr_code;
      phase <= '0;
      armed <= 1'b0;
    end else begin
      if (slot_stb) phase <= last_ph ? '0 : phase + 1'b1;
      if (adc_en)      armed <= 1'b1;
      else if (accept) armed <= 1'b0;
    end
  end

  // observation state for the checks below
  logic              chk_prev_en;
  logic [ECNT_W-1:0] chk_en_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_prev_en <= 1'b0;
      chk_en_cnt  <= '0;
    end else if (odr_chg) begin
      chk_prev_en <= 1'b0;
      chk_en_cnt  <= '0;
    end else if (slot_stb) begin
      chk_prev_en <= adc_en;
      chk_en_cnt  <= last_ph ? '0 : chk_en_cnt + ECNT_W'(adc_en);
    end
  end

  AST_FULL_RATE_EVERY_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_stb && !odr_chg && mode == MD_RAW) |-> adc_en); // R2
  AST_HALF_RATE_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_stb && !odr_chg && mode == MD_GATED && chk_prev_en) |-> !adc_en); // R3
  AST_FILTER_EVERY_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_stb && !odr_chg && mode == MD_FILT) |-> adc_en); // R4
  AST_DUTY_WINDOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_en && mode == MD_DUTY) |-> (int'(chk_en_cnt) < (1 << TLOG_MAX))); // R5

endmodule

// File: rtl/odr_boxcar.sv
module odr_boxcar
  import odr_pkg::*;
#(
  parameter int DATA_W   = 13,
  parameter int TLOG_MAX = 5,
  localparam int TL_W  = $clog2(TLOG_MAX + 1),
  localparam int ACC_W = DATA_W + TLOG_MAX,
  localparam int CNT_W = TLOG_MAX + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     accept,
  input  logic signed [DATA_W-1:0] sample,
  input  logic [TL_W-1:0]          tlog,
  output logic signed [DATA_W-1:0] out_data,
  output logic                     out_valid
);

  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] sum_next;
  logic signed [31:0]      avg;
  logic [CNT_W-1:0]        cnt;
  logic [CNT_W-1:0]        taps_m1;
  logic                    last_tap;

  always_comb begin
    sum_next = acc + {{(ACC_W-DATA_W){sample[DATA_W-1]}}, sample};
    avg      = div_toward_zero({{(32-ACC_W){sum_next[ACC_W-1]}}, sum_next}, int'(tlog));
    taps_m1  = CNT_W'((1 << int'(tlog)) - 1);
    last_tap = (cnt == taps_m1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      cnt       <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (clear) begin
        acc <= '0;
        cnt <= '0;
      end else if (accept) begin
        if (last_tap) begin
          out_data  <= avg[DATA_W-1:0];
          out_valid <= 1'b1;
          acc       <= '0;
          cnt       <= '0;
        end else begin
          acc <= sum_next;
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_TAP_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= taps_m1); // R4
  AST_OUT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(accept)); // R9

endmodule

// File: rtl/odr_rate_seq.sv
module odr_rate_seq
  import odr_pkg::*;
#(
  parameter int DATA_W   = 13,
  parameter int CODE_W   = 4,
  parameter int PLOG_MAX = 9,
  parameter int TLOG_MAX = 5,
  localparam int TL_W = $clog2(TLOG_MAX + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     slot_stb,
  input  logic [CODE_W-1:0]        odr_code,
  input  logic signed [DATA_W-1:0] adc_data,
  input  logic                     adc_valid,
  output logic                     adc_en,
  output logic signed [DATA_W-1:0] out_data,
  output logic                     out_valid
);

  logic      accept;
  logic      odr_chg;
  logic [TL_W-1:0] tlog;
  odr_mode_e mode;

  odr_slot_sched #(
    .CODE_W   (CODE_W),
    .PLOG_MAX (PLOG_MAX),
    .TLOG_MAX (TLOG_MAX)
  ) u_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_stb  (slot_stb),
    .odr_code  (odr_code),
    .adc_valid (adc_valid),
    .adc_en    (adc_en),
    .accept    (accept),
    .odr_chg   (odr_chg),
    .tlog      (tlog),
    .mode      (mode)
  );

  odr_boxcar #(
    .DATA_W   (DATA_W),
    .TLOG_MAX (TLOG_MAX)
  ) u_boxcar (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (odr_chg),
    .accept    (accept),
    .sample    (adc_data),
    .tlog      (tlog),
    .out_data  (out_data),
    .out_valid (out_valid)
  );

  AST_RAW_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ($past(mode) == MD_RAW || $past(mode) == MD_GATED)) |-> out_data == $past(adc_data)); // R2
  AST_FRESH_AFTER_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    odr_chg |=> !out_valid); // R7

endmodule

// File: tb/odr_rate_seq_tb.sv
module odr_rate_seq_tb;

  localparam int STB_GAP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slot_stb = 1'b0;
  logic [3:0] odr_code = 4'hF;
  logic signed [12:0] adc_data = '0;
  logic adc_valid = 1'b0;
  logic adc_en;
  logic signed [12:0] out_data;
  logic out_valid;

  int cyc = 0, n_chk = 0, n_err = 0;
  int m_odr = 15, m_phase = 0, m_sum = 0, m_cnt = 0, e_data = 0;
  bit m_armed = 0, e_valid = 0, prev_ov = 0;
  int due_q[$];
  int smp_idx = 0, data_mode = 0, spur_req_n = 0, spur_done_n = 0;
  int cnt_out = 0, cnt_en = 0, last_out = 0;

  odr_rate_seq u_dut (
    .clk(clk), .rst_n(rst_n), .slot_stb(slot_stb), .odr_code(odr_code),
    .adc_data(adc_data), .adc_valid(adc_valid), .adc_en(adc_en),
    .out_data(out_data), .out_valid(out_valid)
  );

  always #10 clk = ~clk;

  function automatic int m_per(input int c);
    int cc;
    cc = (c < 6) ? 6 : c;
    return 2 ** (15 - cc);
  endfunction

  function automatic int m_taps(input int c);
    if (c >= 14) return 1;
    return (m_per(c) > 32) ? 32 : m_per(c);
  endfunction

  function automatic string tag(input int c);
    if (c == 15) return "R2";
    if (c == 14) return "R3";
    if (c >= 10) return "R4";
    return "R5";
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function int next_sample();
    int v;
    if (data_mode == 1) v = (smp_idx % 4 == 0) ? -2 : -1;
    else v = int'($urandom_range(8191)) - 4096;
    smp_idx++;
    return v;
  endfunction

  // reference model, advanced on every rising edge from the inputs held there
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_odr = 15; m_phase = 0; m_sum = 0; m_cnt = 0; m_armed = 0; e_valid = 0;
    end else begin
      bit chg, men, acc;
      chg = int'(odr_code) != m_odr;
      men = slot_stb && !chg && (m_phase >= m_per(m_odr) - m_taps(m_odr));
      acc = adc_valid && m_armed && !chg;
      e_valid = 0;
      if (chg) begin
        m_odr = int'(odr_code); m_phase = 0; m_sum = 0; m_cnt = 0; m_armed = 0;
      end else begin
        if (acc) begin
          m_sum += int'(adc_data);
          m_cnt++;
          if (m_cnt == m_taps(m_odr)) begin
            e_data = m_sum / m_cnt;
            e_valid = 1;
            m_sum = 0; m_cnt = 0;
          end
        end
        if (slot_stb) m_phase = (m_phase + 1) % m_per(m_odr);
        if (men) m_armed = 1;
        else if (acc) m_armed = 0;
      end
    end
  end

  // converter model: answers two cycles after an enabled slot; also stray pulses
  always @(posedge clk) begin
    #2;
    adc_valid = 1'b0;
    if (due_q.size() > 0 && due_q[0] <= cyc) begin
      void'(due_q.pop_front());
      adc_valid = 1'b1;
      adc_data = 13'(next_sample());
    end else if (spur_done_n != spur_req_n) begin
      spur_done_n = spur_req_n;
      adc_valid = 1'b1;
      adc_data = 13'sh0FFF;
    end
  end

  // per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_en;
      exp_en = slot_stb && (int'(odr_code) == m_odr) && (m_phase >= m_per(m_odr) - m_taps(m_odr));
      chk(adc_en === exp_en, tag(m_odr), "adc_en", int'(adc_en), int'(exp_en));
      if (adc_en === 1'b1) begin
        due_q.push_back(cyc + 2);
        cnt_en++;
      end
      chk(out_valid === e_valid, tag(m_odr), "out_valid", int'(out_valid), int'(e_valid));
      if (out_valid === 1'b1) begin
        cnt_out++;
        last_out = int'(out_data);
        if (e_valid) chk(int'(out_data) == e_data, tag(m_odr), "out_data", int'(out_data), e_data);
        chk(!prev_ov, "R9", "out_valid held two cycles", 1, 0);
      end
      prev_ov = (out_valid === 1'b1);
    end
  end

  task automatic run_slots(input int n);
    for (int i = 0; i < n; i++) begin
      repeat (STB_GAP - 1) @(posedge clk);
      #2 slot_stb = 1'b1;
      @(posedge clk);
      #2 slot_stb = 1'b0;
    end
  endtask

  task automatic settle();
    repeat (8) @(posedge clk);
    #2;
  endtask

  task automatic set_code(input int c);
    @(posedge clk);
    #2 odr_code = 4'(c);
    settle();
    cnt_out = 0;
    cnt_en = 0;
  endtask

  task automatic spur();
    @(posedge clk);
    #2 spur_req_n++;
    repeat (3) @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(adc_en === 1'b0, "R1", "adc_en in reset", int'(adc_en), 0);
    chk(out_valid === 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    @(posedge clk);
    #2 rst_n = 1'b1;
    settle();
    chk(out_valid === 1'b0, "R1", "out_valid idle after reset", int'(out_valid), 0);

    // R2: full rate, held code from reset
    cnt_out = 0; cnt_en = 0;
    run_slots(20); settle();
    chk(cnt_en == 20, "R2", "enabled slots", cnt_en, 20);
    chk(cnt_out == 20, "R2", "outputs", cnt_out, 20);

    // R3: half rate with gating
    set_code(14);
    run_slots(20); settle();
    chk(cnt_en == 10, "R3", "enabled slots", cnt_en, 10);
    chk(cnt_out == 10, "R3", "outputs", cnt_out, 10);

    // R4: filtered decimation
    for (int c = 13; c >= 10; c--) begin
      set_code(c);
      run_slots(2 * m_per(c)); settle();
      chk(cnt_en == 2 * m_per(c), "R4", "enabled slots", cnt_en, 2 * m_per(c));
      chk(cnt_out == 2, "R4", "outputs", cnt_out, 2);
    end

    // R6: rounding toward zero, samples -2,-1,-1,-1
    data_mode = 1; smp_idx = 0;
    set_code(13);
    run_slots(4); settle();
    chk(cnt_out == 1, "R6", "outputs", cnt_out, 1);
    chk(last_out == -1, "R6", "mean of -5/4", last_out, -1);
    data_mode = 0;

    // R5: duty-cycled reporting
    set_code(9);
    run_slots(128); settle();
    chk(cnt_en == 64, "R5", "enabled slots code 9", cnt_en, 64);
    chk(cnt_out == 2, "R5", "outputs code 9", cnt_out, 2);
    set_code(6);
    run_slots(1024); settle();
    chk(cnt_en == 64, "R5", "enabled slots code 6", cnt_en, 64);
    chk(cnt_out == 2, "R5", "outputs code 6", cnt_out, 2);
    set_code(3);
    run_slots(512); settle();
    chk(cnt_en == 32, "R5", "enabled slots code 3", cnt_en, 32);
    chk(cnt_out == 1, "R5", "outputs code 3", cnt_out, 1);

    // R8: stray results ignored
    set_code(15);
    spur(); settle();
    chk(cnt_out == 0, "R8", "output from stray pulse", cnt_out, 0);
    run_slots(1); settle();
    spur(); settle();
    chk(cnt_out == 1, "R8", "outputs after extra pulse", cnt_out, 1);
    set_code(9);
    for (int i = 0; i < 8; i++) begin
      run_slots(1);
      spur();
    end
    settle();
    chk(cnt_en == 0 && cnt_out == 0, "R8", "activity in off slots", cnt_en + cnt_out, 0);
    run_slots(56); settle();
    chk(cnt_out == 1, "R8", "output after stray pulses", cnt_out, 1);

    // R7: rate change in mid-window
    set_code(11);
    run_slots(10);
    set_code(12);
    run_slots(7); settle();
    chk(cnt_out == 0, "R7", "output before full window", cnt_out, 0);
    run_slots(1); settle();
    chk(cnt_out == 1, "R7", "first output after full window", cnt_out, 1);

    finish_run();
  end

endmodule